// File: doc/BRIEF.md
# I2C Target Receiver with Double-Buffered Byte Holding

This block is the receive side of an I2C target port. It works in the system clock domain and watches oversampled SCL and SDA lines. It recognises START and STOP conditions and shifts bus bits, MSB first, into a shift register. Each completed byte is checked against the block's own address. In seven-bit mode one address byte is compared. In ten-bit mode two bytes are compared in turn: a header byte with a fixed prefix, then a low byte. When the block accepts a byte it pulls SDA low during the ninth clock.

Every accepted byte is copied into a holding register that a host reads with a one-cycle strobe. This applies to matched address bytes as well as data bytes. Copying a byte raises a sticky interrupt flag. The shift register and the holding register form a double buffer, so the next byte can already be shifting in while the host still has the previous one unread. If a byte completes while the holding register is still full, the sticky overflow flag is set, the byte is dropped and no ACK is given.

The host configures the block through three inputs: an enable, a mode select and a ten-bit own address. It reads status bits for: START seen, STOP seen, data versus address, transfer direction, and "low address byte expected next".

Top module: `i2c_target_rx`

## Requirements
- R1: While `cfg_en` is low, bus activity has no effect. SDA is never pulled, and no byte reaches the holding register. The START/STOP status bits keep their values.
- R2: A START (SDA falling while SCL is high) sets `stat_start` and clears `stat_stop`. A STOP (SDA rising while SCL is high) sets `stat_stop` and clears `stat_start`.
- R3: In seven-bit mode (`cfg_ten_bit`=0), the first byte after a START matches when its bits [7:1] equal `cfg_addr[6:0]`. On a match, SDA is pulled low for the ninth SCL clock. On a mismatch there is no ACK, and the rest of that transfer is ignored.
- R4: Each accepted byte goes to `rx_byte` and sets `rx_full` and `irq`. `stat_data` is 1 for a data byte and 0 for an address byte.
- R5: A byte may shift in while `rx_full` is set. If `host_rd` is pulsed before that byte completes, the byte is accepted. A `host_rd` pulse clears `rx_full`.
- R6: If a byte that would be accepted completes while `rx_full` is 1, the block sets `rx_ovf`. It does not ACK that byte, and `rx_byte` keeps its old value.
- R7: `irq` is cleared only by `host_irq_clr`, and `rx_ovf` is cleared only by `host_ovf_clr`. Reading the buffer clears neither.
- R8: `stat_read` takes bit 0 of each accepted first address byte after a START (1 = read, 0 = write). In a seven-bit write transfer, data bytes are acknowledged. In a read transfer, no byte is acknowledged or stored.
- R9: In ten-bit mode, the first byte matches when bits [7:3] are 11110 and bits [2:1] equal `cfg_addr[9:8]`. A matching header with bit 0 = 0 is acknowledged and sets `stat_need_lo`. A non-matching header, including any seven-bit-style address, gets no ACK.
- R10: After an accepted ten-bit header, the next byte must equal `cfg_addr[7:0]`. On a match it is acknowledged and the following bytes are data. On a mismatch there is no ACK. In both cases `stat_need_lo` clears.
- R11: A ten-bit header with bit 0 = 1 (read) is accepted only after a full ten-bit write match with no STOP in between. This is the repeated-START case.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (ACK) |
| cfg_en | input | 1 | Block enable |
| cfg_ten_bit | input | 1 | 1 = ten-bit addressing |
| cfg_addr | input | 10 | Own address (seven-bit mode uses [6:0]) |
| host_rd | input | 1 | Holding-register read strobe |
| host_irq_clr | input | 1 | Clears `irq` |
| host_ovf_clr | input | 1 | Clears `rx_ovf` |
| rx_byte | output | 8 | Holding register |
| rx_full | output | 1 | Holding register unread |
| irq | output | 1 | Sticky byte-received flag |
| rx_ovf | output | 1 | Sticky overflow flag |
| stat_start | output | 1 | START seen last |
| stat_stop | output | 1 | STOP seen last |
| stat_data | output | 1 | Last accepted byte was data |
| stat_read | output | 1 | Transfer direction is read |
| stat_need_lo | output | 1 | Ten-bit low address byte expected next |

## Verification
The assertions assume that SCL and SDA each hold a level for several system clocks. They also assume that SDA changes only while SCL is low, except for START and STOP, and that host strobes are single-cycle pulses. Under these conditions the ACK pull falls only within the ninth-clock window, and the holding register stays untouched while it is full. The stimulus holds every quarter of a bus bit for six clocks. It moves SDA only during SCL low, except when forming START and STOP. It pulses host strobes only between bus phases, or while SCL is low in the middle of a byte.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  typedef enum logic [2:0] {
    EN_IDLE,
    EN_ADDR,
    EN_ADDR_LO,
    EN_WRITE,
    EN_READ,
    EN_SKIP
  } eng_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp
  import i2c_target_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr,
  output logic              m7,
  output logic              m10_hdr,
  output logic              m10_lo,
  output logic              rw
);
  assign m7      = (byte_i[BYTE_W-1:1] == own_addr[BYTE_W-2:0]);
  assign m10_hdr = (byte_i[7:3] == TEN_PREFIX) && (byte_i[2:1] == own_addr[ADDR_W-1:ADDR_W-2]);
  assign m10_lo  = (byte_i == own_addr[BYTE_W-1:0]);
  assign rw      = byte_i[0];
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_target_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ten_bit,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              buf_full,
  output logic              sda_pull,
  output logic              dlv,
  output logic [BYTE_W-1:0] dlv_byte,
  output logic              dlv_is_data,
  output logic              ovf_pulse,
  output logic              rw_set,
  output logic              rw_val,
  output logic              need_lo
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  eng_state_t        state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] nb;
  logic              ack_pend, ten_ok;
  logic              m7, m10_hdr, m10_lo, rw;
  logic              want, kind_data, lo_next, ten_done, set_rw;

  assign nb = {shreg, sda_s};

  i2c_addr_cmp u_cmp (
    .byte_i  (nb),
    .own_addr(own_addr),
    .m7      (m7),
    .m10_hdr (m10_hdr),
    .m10_lo  (m10_lo),
    .rw      (rw)
  );

  always_comb begin
    want      = 1'b0;
    nxt       = EN_SKIP;
    kind_data = 1'b0;
    lo_next   = 1'b0;
    ten_done  = 1'b0;
    set_rw    = 1'b0;
    case (state)
      EN_ADDR: begin
        if (ten_bit) begin
          if (m10_hdr && !rw) begin
            want = 1'b1; nxt = EN_ADDR_LO; lo_next = 1'b1; set_rw = 1'b1;
          end else if (m10_hdr && rw && ten_ok) begin
            want = 1'b1; nxt = EN_READ; set_rw = 1'b1;
          end
        end else if (m7) begin
          want = 1'b1; set_rw = 1'b1;
          nxt  = rw ? EN_READ : EN_WRITE;
        end
      end
      EN_ADDR_LO: begin
        if (m10_lo) begin
          want = 1'b1; nxt = EN_WRITE; ten_done = 1'b1;
        end
      end
      EN_WRITE: begin
        want = 1'b1; nxt = EN_WRITE; kind_data = 1'b1;
      end
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= EN_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      ack_pend    <= 1'b0;
      sda_pull    <= 1'b0;
      ten_ok      <= 1'b0;
      need_lo     <= 1'b0;
      dlv         <= 1'b0;
      dlv_byte    <= '0;
      dlv_is_data <= 1'b0;
      ovf_pulse   <= 1'b0;
      rw_set      <= 1'b0;
      rw_val      <= 1'b0;
    end else begin
      dlv       <= 1'b0;
      ovf_pulse <= 1'b0;
      rw_set    <= 1'b0;
      if (!en) begin
        state    <= EN_IDLE;
        cnt      <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
        ten_ok   <= 1'b0;
        need_lo  <= 1'b0;
      end else if (start_det) begin
        state    <= EN_ADDR;
        cnt      <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
        need_lo  <= 1'b0;
      end else if (stop_det) begin
        state    <= EN_IDLE;
        cnt      <= '0;
        ack_pend <= 1'b0;
        sda_pull <= 1'b0;
        ten_ok   <= 1'b0;
        need_lo  <= 1'b0;
      end else if (state != EN_IDLE) begin
        if (scl_rise) begin
          if (cnt != ACK_SLOT) begin
            shreg <= nb[BYTE_W-2:0];
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              if (want && !buf_full) begin
                dlv         <= 1'b1;
                dlv_byte    <= nb;
                dlv_is_data <= kind_data;
                ack_pend    <= 1'b1;
                state       <= nxt;
                need_lo     <= lo_next;
                if (ten_done) ten_ok <= 1'b1;
                if (set_rw) begin
                  rw_set <= 1'b1;
                  rw_val <= rw;
                end
              end else if (want) begin
                ovf_pulse <= 1'b1;
                need_lo   <= 1'b0;
                state     <= (state == EN_WRITE) ? EN_WRITE : EN_SKIP;
              end else begin
                need_lo <= 1'b0;
                state   <= nxt;
              end
            end
          end else begin
            cnt <= '0;
          end
        end
        if (scl_fall) begin
          if (cnt == ACK_SLOT && ack_pend) begin
            sda_pull <= 1'b1;
            ack_pend <= 1'b0;
          end else if (cnt == '0) begin
            sda_pull <= 1'b0;
          end
        end
      end
    end
  end

  // R3: the ACK pull stays inside the ninth-clock window
  a_r3_ack_window: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (cnt == ACK_SLOT || cnt == '0));

  // R1: a disabled block releases SDA on the next cycle
  a_r1_off_release: assert property (@(posedge clk) disable iff (rst)
    !en |=> !sda_pull);

  // R6: a dropped byte never reaches the holding register in the same step
  a_r6_no_dual: assert property (@(posedge clk) disable iff (rst)
    !(dlv && ovf_pulse));
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
  import i2c_target_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              cfg_en,
  input  logic              cfg_ten_bit,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              host_rd,
  input  logic              host_irq_clr,
  input  logic              host_ovf_clr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_full,
  output logic              irq,
  output logic              rx_ovf,
  output logic              stat_start,
  output logic              stat_stop,
  output logic              stat_data,
  output logic              stat_read,
  output logic              stat_need_lo
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic dlv, dlv_is_data, ovf_pulse, rw_set, rw_val;
  logic [BYTE_W-1:0] dlv_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_byte_engine u_eng (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg_en),
    .ten_bit    (cfg_ten_bit),
    .own_addr   (cfg_addr),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .buf_full   (rx_full),
    .sda_pull   (sda_pull_o),
    .dlv        (dlv),
    .dlv_byte   (dlv_byte),
    .dlv_is_data(dlv_is_data),
    .ovf_pulse  (ovf_pulse),
    .rw_set     (rw_set),
    .rw_val     (rw_val),
    .need_lo    (stat_need_lo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte    <= '0;
      rx_full    <= 1'b0;
      irq        <= 1'b0;
      rx_ovf     <= 1'b0;
      stat_start <= 1'b0;
      stat_stop  <= 1'b0;
      stat_data  <= 1'b0;
      stat_read  <= 1'b0;
    end else begin
      if (dlv) begin
        rx_byte   <= dlv_byte;
        rx_full   <= 1'b1;
        stat_data <= dlv_is_data;
      end else if (host_rd) begin
        rx_full <= 1'b0;
      end
      if (dlv) irq <= 1'b1;
      else if (host_irq_clr) irq <= 1'b0;
      if (ovf_pulse) rx_ovf <= 1'b1;
      else if (host_ovf_clr) rx_ovf <= 1'b0;
      if (rw_set) stat_read <= rw_val;
      if (cfg_en && start_det) begin
        stat_start <= 1'b1;
        stat_stop  <= 1'b0;
      end else if (cfg_en && stop_det) begin
        stat_start <= 1'b0;
        stat_stop  <= 1'b1;
      end
    end
  end

  a_r2_sp_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(stat_start && stat_stop));

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !host_irq_clr |=> irq);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_ovf && !host_ovf_clr |=> rx_ovf);

  a_r4_irq_with_full: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> rx_full);

  a_r6_hold_while_full: assert property (@(posedge clk) disable iff (rst)
    rx_full && !host_rd |=> $stable(rx_byte));
endmodule

// File: tb/i2c_target_rx_tb.sv
module i2c_target_rx_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic cfg_en = 1'b1, cfg_ten_bit = 1'b0;
  logic [9:0] cfg_addr = 10'h02A;
  logic host_rd = 1'b0, host_irq_clr = 1'b0, host_ovf_clr = 1'b0;
  logic sda_pull_o, rx_full, irq, rx_ovf;
  logic stat_start, stat_stop, stat_data, stat_read, stat_need_lo;
  logic [7:0] rx_byte;
  logic sda_bus;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_pull_o;

  always #4 clk = ~clk;

  i2c_target_rx u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull_o),
    .cfg_en(cfg_en), .cfg_ten_bit(cfg_ten_bit), .cfg_addr(cfg_addr),
    .host_rd(host_rd), .host_irq_clr(host_irq_clr), .host_ovf_clr(host_ovf_clr),
    .rx_byte(rx_byte), .rx_full(rx_full), .irq(irq), .rx_ovf(rx_ovf),
    .stat_start(stat_start), .stat_stop(stat_stop), .stat_data(stat_data),
    .stat_read(stat_read), .stat_need_lo(stat_need_lo)
  );

  // {addr byte, data byte, addr ack expected, data ack expected}
  localparam logic [17:0] VEC [0:5] = '{
    {8'h54, 8'h3C, 1'b1, 1'b1},
    {8'h54, 8'hFF, 1'b1, 1'b1},
    {8'h56, 8'h11, 1'b0, 1'b0},
    {8'h55, 8'hA5, 1'b1, 1'b0},
    {8'h00, 8'h00, 1'b0, 1'b0},
    {8'hD4, 8'h99, 1'b0, 1'b0}
  };

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_rd();
    host_rd = 1'b1; waitc(1); host_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int rd_at, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(Q);
      scl_m = 1'b1; waitc(2 * Q);
      scl_m = 1'b0; waitc(Q);
      if (i == rd_at) pulse_rd();
    end
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    ack = ~sda_bus; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic ack;
    waitc(4);
    rst = 1'b0;
    waitc(2);
    // R12 reset state
    chk("R12 flags", {rx_byte, rx_full, irq, rx_ovf, stat_start, stat_stop,
                      stat_data, stat_read, stat_need_lo}, 16'h0);
    chk("R12 sda_pull", sda_pull_o, 0);

    // table walk, seven-bit mode
    for (int k = 0; k < 6; k++) begin
      logic [7:0] ab, db;
      logic ea, ed;
      {ab, db, ea, ed} = VEC[k];
      host_irq_clr = 1'b1; waitc(1); host_irq_clr = 1'b0;
      bus_start();
      chk("R2 start sets S", {stat_start, stat_stop}, 2'b10);
      send_byte(ab, -1, ack);
      chk("R3 address ack", ack, ea);
      if (ea) begin
        chk("R4 addr stored", {rx_full, irq, stat_data, rx_byte}, {3'b110, ab});
        chk("R8 direction", stat_read, ab[0]);
        pulse_rd(); waitc(1);
        chk("R5 read clears full", rx_full, 0);
      end
      send_byte(db, -1, ack);
      chk("R3/R8 data ack", ack, ed);
      if (ed) begin
        chk("R4 data stored", {rx_full, stat_data, rx_byte}, {2'b11, db});
        pulse_rd();
      end else begin
        chk("R3 ignored byte not stored", rx_full, 0);
      end
      bus_stop();
      chk("R2 stop sets P", {stat_start, stat_stop}, 2'b01);
    end

    // R1 disabled block ignores the bus
    cfg_en = 1'b0;
    bus_start();
    send_byte(8'h54, -1, ack);
    chk("R1 no ack when off", ack, 0);
    chk("R1 no store when off", rx_full, 0);
    bus_stop();
    bus_start();
    chk("R1 status kept when off", {stat_start, stat_stop}, 2'b01);
    bus_stop();
    cfg_en = 1'b1;

    // R5, R6, R7 double buffering and overflow
    bus_start();
    send_byte(8'h54, -1, ack);
    pulse_rd();
    send_byte(8'h12, -1, ack);
    chk("R5 first data ack", ack, 1);
    send_byte(8'h34, -1, ack);
    chk("R6 overflow no ack", ack, 0);
    chk("R6 overflow flag", rx_ovf, 1);
    chk("R6 buffer kept", rx_byte, 8'h12);
    send_byte(8'h77, 3, ack);
    chk("R5 read mid-byte accepts", {ack, rx_byte}, {1'b1, 8'h77});
    pulse_rd(); waitc(1);
    chk("R7 read keeps irq/ovf", {irq, rx_ovf}, 2'b11);
    host_ovf_clr = 1'b1; waitc(1); host_ovf_clr = 1'b0; waitc(1);
    chk("R7 ovf clear", {irq, rx_ovf}, 2'b10);
    host_irq_clr = 1'b1; waitc(1); host_irq_clr = 1'b0; waitc(1);
    chk("R7 irq clear", irq, 0);
    bus_stop();

    // ten-bit mode: address 0x32A, header 0xF6/0xF7, low 0x2A
    cfg_ten_bit = 1'b1;
    cfg_addr = 10'h32A;
    bus_start();
    send_byte(8'hF6, -1, ack);
    chk("R9 header ack", {ack, stat_need_lo, stat_read, stat_data, rx_byte}, {4'b1100, 8'hF6});
    pulse_rd();
    send_byte(8'h2A, -1, ack);
    chk("R10 low byte ack", {ack, stat_need_lo, rx_byte}, {2'b10, 8'h2A});
    pulse_rd();
    send_byte(8'h5A, -1, ack);
    chk("R10 data after match", {ack, stat_data, rx_byte}, {2'b11, 8'h5A});
    pulse_rd();
    bus_start();
    send_byte(8'hF7, -1, ack);
    chk("R11 read header after restart", {ack, stat_read}, 2'b11);
    pulse_rd();
    bus_stop();

    bus_start();
    send_byte(8'hF7, -1, ack);
    chk("R11 read header after stop refused", {ack, rx_full}, 2'b00);
    bus_stop();

    bus_start();
    send_byte(8'hF6, -1, ack);
    pulse_rd();
    send_byte(8'h2B, -1, ack);
    chk("R10 low mismatch", {ack, stat_need_lo, rx_full}, 3'b000);
    bus_stop();

    bus_start();
    send_byte(8'hF4, -1, ack);
    chk("R9 wrong high bits", {ack, stat_need_lo}, 2'b00);
    bus_stop();

    bus_start();
    send_byte(8'h54, -1, ack);
    chk("R9 seven-bit byte refused", ack, 0);
    bus_stop();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    done = 1'b1;
    $finish;
  end
endmodule